// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block is the purely combinational hazard controller of a five-stage in-order processor pipeline (fetch, decode, execute, memory, write-back). It looks at the opcode held in each relevant stage, at the register that a load in execute will write, at the source registers the decode stage needs, at the branch outcome computed in execute, and at the status codes leaving the memory and write-back stages. From these it drives hold (stall) and flush (bubble) controls for the pipeline registers and an enable for the condition-code register. The pipeline registers sample these controls at their next rising clock edge. When the fetch register is held, its predicted program counter is held with it.

Four situations are resolved: a return instruction waiting for its target address, a load whose result is needed one cycle too early, a conditional jump that was predicted taken but falls through, and a faulting instruction that must stop everything younger than itself. Forwarding and the pipeline registers themselves sit outside this block.

Top module: `hz_pipe_ctrl`

## Requirements
- R1: Opcodes are 4-bit codes: halt 0x0, nop 0x1, reg-move 0x2, imm-move 0x3, store 0x4, load 0x5, alu-op 0x6, jump 0x7, call 0x8, return 0x9, push 0xA, pop 0xB. Status codes are 2-bit: OK 0, halted 1, bad address 2, bad instruction 3. With every stage holding nop and both statuses OK, all hold and flush outputs are 0.
- R2: When execute holds load (0x5) or pop (0xB) and its memory destination equals the decode stage's source A or source B, fetch and decode are held, execute gets a bubble, and decode does not get a bubble.
- R3: A destination of 0xF means no register; it never causes a load/use hold, even when a decode source is also 0xF. A load whose destination matches neither source causes no hold.
- R4: When execute holds jump (0x7) with its condition false, decode and execute get bubbles and fetch is not held; with the condition true no control is raised.
- R5: When return (0x9) is in decode, execute or memory and there is no load/use hazard, fetch is held and decode gets a bubble.
- R6: When return is pending together with a load/use hazard, the load/use response wins: fetch and decode held, execute bubbled, decode not bubbled. Decode is never held and bubbled at once.
- R7: When the memory status or the write-back status is not OK, memory gets a bubble.
- R8: When the write-back status is not OK, write-back is held; a bad memory status alone does not hold write-back.
- R9: The condition-code enable is 1 only when execute holds alu-op (0x6) and both the memory and write-back statuses are OK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_opcode | input | 4 | Opcode in the decode stage |
| e_opcode | input | 4 | Opcode in the execute stage |
| m_opcode | input | 4 | Opcode in the memory stage |
| d_src_a | input | 4 | First source register of decode |
| d_src_b | input | 4 | Second source register of decode |
| e_dst_mem | input | 4 | Register execute's load will write, 0xF for none |
| e_cnd | input | 1 | Branch condition computed in execute |
| m_stat | input | 2 | Status out of the memory stage |
| w_stat | input | 2 | Status in the write-back stage |
| f_stall | output | 1 | Hold the fetch register and predicted PC |
| d_stall | output | 1 | Hold the decode register |
| d_bubble | output | 1 | Flush the decode register to nop |
| e_bubble | output | 1 | Flush the execute register to nop |
| m_bubble | output | 1 | Flush the memory register to nop |
| w_stall | output | 1 | Hold the write-back register |
| cc_wr_en | output | 1 | Allow the condition codes to update |

## Verification
Because the unit holds no state, a wrong internal decision shows on the control outputs in the same cycle its inputs are applied, with no latency to wait for. A broken register compare shows as a missing or spurious fetch/decode hold and execute bubble; a wrong priority between return and load/use shows as decode being flushed instead of held, which in a real pipeline silently drops the consumer instruction. A faulty status gate shows as the condition-code enable staying high behind a faulting instruction, so the bench pairs each status value with an alu-op in execute.

// File: rtl/hz_pkg.sv
package hz_pkg;

   localparam int OPC_W  = 4;
   localparam int STAT_W = 2;

   localparam logic [OPC_W-1:0] OPC_HALT  = 4'h0;
   localparam logic [OPC_W-1:0] OPC_NOP   = 4'h1;
   localparam logic [OPC_W-1:0] OPC_RRMV  = 4'h2;
   localparam logic [OPC_W-1:0] OPC_IRMV  = 4'h3;
   localparam logic [OPC_W-1:0] OPC_STORE = 4'h4;
   localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h5;
   localparam logic [OPC_W-1:0] OPC_ALU   = 4'h6;
   localparam logic [OPC_W-1:0] OPC_JUMP  = 4'h7;
   localparam logic [OPC_W-1:0] OPC_CALL  = 4'h8;
   localparam logic [OPC_W-1:0] OPC_RET   = 4'h9;
   localparam logic [OPC_W-1:0] OPC_PUSH  = 4'hA;
   localparam logic [OPC_W-1:0] OPC_POP   = 4'hB;

   localparam logic [STAT_W-1:0] ST_OK  = 2'd0;
   localparam logic [STAT_W-1:0] ST_HLT = 2'd1;
   localparam logic [STAT_W-1:0] ST_ADR = 2'd2;
   localparam logic [STAT_W-1:0] ST_INS = 2'd3;

   typedef struct packed {
      logic f_stall;
      logic d_stall;
      logic d_bubble;
      logic e_bubble;
      logic m_bubble;
      logic w_stall;
   } pipe_ctl_t;

endpackage

// File: rtl/hz_load_use.sv
module hz_load_use
   import hz_pkg::*;
#(
   parameter int REG_W   = 4,
   parameter int NUM_SRC = 2
) (
   input  logic [OPC_W-1:0]              e_opcode,
   input  logic [REG_W-1:0]              e_dst,
   input  logic [NUM_SRC-1:0][REG_W-1:0] d_src,
   output logic                          hazard
);
   localparam logic [REG_W-1:0] NO_REG = '1;

   logic                is_load;
   logic [NUM_SRC-1:0]  src_hit;

   assign is_load = (e_opcode == OPC_LOAD) || (e_opcode == OPC_POP);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign src_hit[i] = (d_src[i] == e_dst);
   end

   assign hazard = is_load && (e_dst != NO_REG) && (|src_hit);

endmodule

// File: rtl/hz_ret_watch.sv
module hz_ret_watch
   import hz_pkg::*;
#(
   parameter int N_STAGES = 3
) (
   input  logic [N_STAGES-1:0][OPC_W-1:0] stage_opc,
   output logic                           ret_pending
);
   logic [N_STAGES-1:0] is_ret;

   for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
      assign is_ret[s] = (stage_opc[s] == OPC_RET);
   end

   assign ret_pending = |is_ret;

endmodule

// File: rtl/hz_status_gate.sv
module hz_status_gate
   import hz_pkg::*;
(
   input  logic [STAT_W-1:0] m_stat,
   input  logic [STAT_W-1:0] w_stat,
   output logic              m_fault,
   output logic              w_fault,
   output logic              younger_ok
);
   assign m_fault    = (m_stat != ST_OK);
   assign w_fault    = (w_stat != ST_OK);
   assign younger_ok = !m_fault && !w_fault;
endmodule

// File: rtl/hz_pipe_ctrl.sv
module hz_pipe_ctrl
   import hz_pkg::*;
#(
   parameter int REG_W = 4
) (
   input  logic [OPC_W-1:0]  d_opcode,
   input  logic [OPC_W-1:0]  e_opcode,
   input  logic [OPC_W-1:0]  m_opcode,
   input  logic [REG_W-1:0]  d_src_a,
   input  logic [REG_W-1:0]  d_src_b,
   input  logic [REG_W-1:0]  e_dst_mem,
   input  logic              e_cnd,
   input  logic [STAT_W-1:0] m_stat,
   input  logic [STAT_W-1:0] w_stat,
   output logic              f_stall,
   output logic              d_stall,
   output logic              d_bubble,
   output logic              e_bubble,
   output logic              m_bubble,
   output logic              w_stall,
   output logic              cc_wr_en
);
   localparam int NUM_SRC   = 2;
   localparam int RET_DEPTH = 3;

   if (REG_W < 2 || REG_W > 8) begin : g_bad_reg_w
      $error("hz_pipe_ctrl: REG_W out of supported range");
   end

   logic [NUM_SRC-1:0][REG_W-1:0]   src_vec;
   logic [RET_DEPTH-1:0][OPC_W-1:0] ret_opc;
   logic lu_hz, ret_hz, mispred, m_fault, w_fault, younger_ok;
   pipe_ctl_t ctl;

   assign src_vec = {d_src_b, d_src_a};
   assign ret_opc = {m_opcode, e_opcode, d_opcode};

   hz_load_use #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_load_use (
      .e_opcode (e_opcode),
      .e_dst    (e_dst_mem),
      .d_src    (src_vec),
      .hazard   (lu_hz)
   );

   hz_ret_watch #(.N_STAGES(RET_DEPTH)) u_ret_watch (
      .stage_opc   (ret_opc),
      .ret_pending (ret_hz)
   );

   hz_status_gate u_status (
      .m_stat     (m_stat),
      .w_stat     (w_stat),
      .m_fault    (m_fault),
      .w_fault    (w_fault),
      .younger_ok (younger_ok)
   );

   assign mispred = (e_opcode == OPC_JUMP) && !e_cnd;

   always_comb begin
      ctl          = '0;
      ctl.f_stall  = lu_hz || ret_hz;
      ctl.d_stall  = lu_hz;
      ctl.d_bubble = mispred || (ret_hz && !lu_hz);
      ctl.e_bubble = mispred || lu_hz;
      ctl.m_bubble = m_fault || w_fault;
      ctl.w_stall  = w_fault;
   end

   assign f_stall  = ctl.f_stall;
   assign d_stall  = ctl.d_stall;
   assign d_bubble = ctl.d_bubble;
   assign e_bubble = ctl.e_bubble;
   assign m_bubble = ctl.m_bubble;
   assign w_stall  = ctl.w_stall;
   assign cc_wr_en = (e_opcode == OPC_ALU) && younger_ok;

   always_comb begin
      assert_d_exclusive_R6: assert (!(d_stall && d_bubble))
         else $error("decode held and flushed together");
      assert_lu_response_R2: assert (!lu_hz || (f_stall && e_bubble && !d_bubble))
         else $error("load/use response incomplete");
      assert_ret_hold_R5: assert (!ret_hz || f_stall)
         else $error("return pending without fetch hold");
      assert_m_flush_R7: assert (!w_stall || m_bubble)
         else $error("write-back held without memory flush");
      assert_cc_block_R9: assert (!cc_wr_en || younger_ok)
         else $error("condition codes enabled behind a fault");
   end

endmodule

// File: tb/hz_pipe_ctrl_tb.sv
module hz_pipe_ctrl_tb;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [3:0] d_opcode, e_opcode, m_opcode, d_src_a, d_src_b, e_dst_mem;
   logic       e_cnd;
   logic [1:0] m_stat, w_stat;
   logic f_stall, d_stall, d_bubble, e_bubble, m_bubble, w_stall, cc_wr_en;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   hz_pipe_ctrl u_dut (
      .d_opcode(d_opcode), .e_opcode(e_opcode), .m_opcode(m_opcode),
      .d_src_a(d_src_a), .d_src_b(d_src_b), .e_dst_mem(e_dst_mem),
      .e_cnd(e_cnd), .m_stat(m_stat), .w_stat(w_stat),
      .f_stall(f_stall), .d_stall(d_stall), .d_bubble(d_bubble),
      .e_bubble(e_bubble), .m_bubble(m_bubble), .w_stall(w_stall),
      .cc_wr_en(cc_wr_en)
   );

   task automatic idle();
      d_opcode = 4'h1; e_opcode = 4'h1; m_opcode = 4'h1;
      d_src_a = 4'hF; d_src_b = 4'hF; e_dst_mem = 4'hF;
      e_cnd = 1'b0; m_stat = 2'd0; w_stat = 2'd0;
   endtask

   // expected order: f_stall d_stall d_bubble e_bubble m_bubble w_stall cc_wr_en
   task automatic check(string req, logic [6:0] exp);
      logic [6:0] act;
      @(negedge clk);
      #2;
      act = {f_stall, d_stall, d_bubble, e_bubble, m_bubble, w_stall, cc_wr_en};
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic t_idle_r1();
      idle();
      check("R1 idle", 7'b0000000);
   endtask

   task automatic t_load_use_r2();
      idle(); e_opcode = 4'h5; e_dst_mem = 4'h3; d_src_a = 4'h3;
      check("R2 load hits srcA", 7'b1101000);
      idle(); e_opcode = 4'hB; e_dst_mem = 4'h6; d_src_b = 4'h6;
      check("R2 pop hits srcB", 7'b1101000);
   endtask

   task automatic t_no_reg_r3();
      idle(); e_opcode = 4'h5; e_dst_mem = 4'hF;
      check("R3 none matches none", 7'b0000000);
      idle(); e_opcode = 4'h5; e_dst_mem = 4'h2; d_src_a = 4'h1; d_src_b = 4'h4;
      check("R3 no match", 7'b0000000);
      idle(); e_opcode = 4'h2; e_dst_mem = 4'h2; d_src_a = 4'h2;
      check("R3 non-load opcode", 7'b0000000);
   endtask

   task automatic t_mispredict_r4();
      idle(); e_opcode = 4'h7; e_cnd = 1'b0;
      check("R4 not taken", 7'b0011000);
      idle(); e_opcode = 4'h7; e_cnd = 1'b1;
      check("R4 taken", 7'b0000000);
   endtask

   task automatic t_ret_r5();
      for (int s = 0; s < 3; s++) begin
         idle();
         if (s == 0) d_opcode = 4'h9;
         else if (s == 1) e_opcode = 4'h9;
         else m_opcode = 4'h9;
         check("R5 return pending", 7'b1010000);
      end
   endtask

   task automatic t_ret_lu_r6();
      idle(); d_opcode = 4'h9; e_opcode = 4'h5; e_dst_mem = 4'h4; d_src_a = 4'h4;
      check("R6 return with load/use", 7'b1101000);
      idle(); m_opcode = 4'h9; e_opcode = 4'hB; e_dst_mem = 4'h4; d_src_b = 4'h4;
      check("R6 return in mem with pop/use", 7'b1101000);
   endtask

   task automatic t_faults_r7_r8();
      idle(); m_stat = 2'd2;
      check("R7 memory fault", 7'b0000100);
      idle(); m_stat = 2'd3;
      check("R8 memory fault leaves write-back", 7'b0000100);
      idle(); w_stat = 2'd1;
      check("R8 write-back fault", 7'b0000110);
      idle(); m_stat = 2'd1; w_stat = 2'd2;
      check("R7 both faulted", 7'b0000110);
   endtask

   task automatic t_cc_r9();
      idle(); e_opcode = 4'h6;
      check("R9 alu-op enables", 7'b0000001);
      for (int st = 1; st < 4; st++) begin
         idle(); e_opcode = 4'h6; m_stat = st[1:0];
         check("R9 memory fault blocks", 7'b0000100);
         idle(); e_opcode = 4'h6; w_stat = st[1:0];
         check("R9 write-back fault blocks", 7'b0000110);
      end
      idle(); e_opcode = 4'h2;
      check("R9 non-alu", 7'b0000000);
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      idle();
      t_idle_r1();
      t_load_use_r2();
      t_no_reg_r3();
      t_mispredict_r4();
      t_ret_r5();
      t_ret_lu_r6();
      t_faults_r7_r8();
      t_cc_r9();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule